// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is one counter channel that turns a trigger edge into a single timed pulse. Each pulse has two parts. First comes an idle-level stretch whose length is held in the delay constant. Then comes an asserted stretch whose length is held in the width constant. Both lengths are counted in ticks of a selectable count clock. The count clock is either every system clock cycle or each rising edge of an external clock pin. The external pin is synchronized and edge-detected into the system clock domain.

A hold-off pin freezes the channel while it is asserted. Pin polarities, the trigger pin's edge, the output level, optional input debounce and a sticky completion flag are set through a 16-bit control word. Software writes the control word and the two constants through a simple write port. A new trigger edge that arrives mid-pulse restarts the sequence from the start of the delay stretch.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: After reset all three registers are zero, the channel is idle, `irq` is 0 and `pulse_out` is 1, which is the idle level for an active-low output.
- R2: The channel runs only when control bits [2:0] equal 3'b111. Any other value keeps it idle, holds `pulse_out` at its idle level and ignores triggers.
- R3: Control bits [9:8] select the trigger. 2'b10 means a rising edge on `trig_in`, 2'b01 means a falling edge, and 2'b00 or 2'b11 means every edge is ignored.
- R4: With debounce off, a trigger edge on the pin starts the delay stretch after SYNC_STAGES+1 rising clock edges. The delay stretch lasts `len_a` ticks and the asserted stretch lasts `len_b` ticks. The output then returns to idle and the channel waits for the next trigger.
- R5: A constant of zero counts as 2^CNT_W ticks.
- R6: Control bit 3 set makes the asserted level of `pulse_out` high. Bit 3 clear makes the asserted level low and the idle level high.
- R7: A trigger edge during either stretch restarts the delay stretch from zero.
- R8: Control bits [5:4] configure the hold-off pin `gate_in`. 2'b10 means active high, 2'b01 means active low, and 2'b00 or 2'b11 means off. While hold-off is active, no count advances, `pulse_out` holds its level and trigger edges are ignored.
- R9: When bits [12:10] equal 3'b101 and bits [7:6] equal 2'b01, one tick is counted per rising edge of `clk_in`. Otherwise one tick is counted per system clock cycle.
- R10: Control bit 13 set filters `gate_in` and `trig_in`. A new level is accepted only after it has held for DEB_CYCLES consecutive clock cycles, which adds that many cycles of latency.
- R11: When control bit 15 is set, `irq` is set as the asserted stretch ends. It stays set until the next control write clears it. When bit 15 is clear, `irq` stays 0.
- R12: Write address 0 holds the control word (bit 14 unused), address 1 holds `len_a` and address 2 holds `len_b`. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| gate_in | input | 1 | Hold-off pin, asynchronous |
| clk_in | input | 1 | External count clock pin, asynchronous |
| trig_in | input | 1 | Trigger pin, asynchronous |
| pulse_out | output | 1 | Pulse output |
| irq | output | 1 | Sticky completion flag |

## Verification
The bench builds the block with its defaults: CNT_W of 16, two synchronizer stages and DEB_CYCLES of 4. With these values, pin-to-phase latency, debounce latency and hold-off freeze each come out as exact cycle counts. The 16-bit counter keeps the zero-constant case to 65,536 ticks, so the full count wrap can be run. A four-cycle external clock checks that the asserted width scales with external ticks rather than system cycles.

// File: rtl/ospg_pkg.sv
package ospg_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } phase_t;

   // control word with the unused bit 14 dropped
   typedef struct packed {
      logic       irq_en;
      logic       deb_en;
      logic [2:0] clk_src;
      logic [1:0] trig_cfg;
      logic [1:0] clkin_cfg;
      logic [1:0] gate_cfg;
      logic       act_high;
      logic [2:0] mode;
   } ctrl_t;

   localparam logic [2:0] MODE_ONESHOT = 3'b111;
   localparam logic [2:0] CLKSRC_EXT   = 3'b101;
   localparam logic [1:0] CLKIN_ON     = 2'b01;
   localparam logic [1:0] LVL_HIGH     = 2'b10;
   localparam logic [1:0] LVL_LOW      = 2'b01;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_LEN_A = 2'd1;
   localparam logic [1:0] ADDR_LEN_B = 2'd2;

endpackage

// File: rtl/ospg_sync.sv
module ospg_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ospg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ospg_debounce.sv
module ospg_debounce #(
   parameter int HOLD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic filt
);
   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("ospg_debounce: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic filt_q;

   generate
      if (HOLD_CYCLES == 1) begin : g_follow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_q <= 1'b0;
            else        filt_q <= raw;
         end
      end else begin : g_count
         localparam int CW = $clog2(HOLD_CYCLES + 1);
         localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_q <= 1'b0;
               run_q  <= '0;
            end else if (raw == filt_q) begin
               run_q <= '0;
            end else if (run_q == LAST) begin
               filt_q <= raw;
               run_q  <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign filt = filt_q;

   // a new filtered level is always one the raw input held before the edge
   assert_filter_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(filt_q) |-> ($past(raw) == filt_q));
endmodule

// File: rtl/ospg_phase_seq.sv
module ospg_phase_seq
   import ospg_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             start,
   input  logic             tick,
   input  logic [CNT_W-1:0] len_a,
   input  logic [CNT_W-1:0] len_b,
   output phase_t           phase,
   output logic             phase_end
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_t           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_a;
   logic             last_b;

   // count up to len-1; a zero constant wraps to the full 2^CNT_W range
   assign last_a = (cnt_q == len_a - ONE);
   assign last_b = (cnt_q == len_b - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (!armed) begin
         phase_q <= ST_IDLE;
         cnt_q   <= '0;
      end else if (start) begin
         phase_q <= ST_LOW;
         cnt_q   <= '0;
      end else if (tick) begin
         unique case (phase_q)
            ST_LOW: begin
               if (last_a) begin
                  phase_q <= ST_HIGH;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            ST_HIGH: begin
               if (last_b) begin
                  phase_q <= ST_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + ONE;
               end
            end
            default: cnt_q <= '0;
         endcase
      end
   end

   assign phase     = phase_q;
   assign phase_end = armed && !start && tick && (phase_q == ST_HIGH) && last_b;

   assert_freeze_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !start && !tick) |=> ($stable(phase_q) && $stable(cnt_q)));

   assert_restart_on_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && start) |=> (phase_q == ST_LOW && cnt_q == '0));

   assert_high_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == ST_HIGH) |-> ($past(phase_q) == ST_LOW || $past(phase_q) == ST_HIGH));
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
   import ospg_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [15:0] wr_data,
   input  logic        gate_in,
   input  logic        clk_in,
   input  logic        trig_in,
   output logic        pulse_out,
   output logic        irq
);
   localparam int PIN_W = 3;  // {trigger, ext clock, hold-off}

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("oneshot_pulse_gen: CNT_W must lie in 2..16");
      end
   endgenerate

   // register file
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] len_a_q;
   logic [CNT_W-1:0] len_b_q;
   logic             ctrl_wr;

   assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         len_a_q <= '0;
         len_b_q <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            ADDR_CTRL:  ctrl_q  <= {wr_data[15], wr_data[13:0]};
            ADDR_LEN_A: len_a_q <= wr_data[CNT_W-1:0];
            ADDR_LEN_B: len_b_q <= wr_data[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   // pin synchronization
   logic [PIN_W-1:0] pin_sync;

   ospg_sync #(.STAGES(SYNC_STAGES), .W(PIN_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({trig_in, clk_in, gate_in}),
      .q     (pin_sync)
   );

   // optional debounce on hold-off (index 0) and trigger (index 1)
   logic [1:0] deb_raw;
   logic [1:0] deb_filt;
   assign deb_raw = {pin_sync[2], pin_sync[0]};

   generate
      for (genvar i = 0; i < 2; i++) begin : g_deb
         ospg_debounce #(.HOLD_CYCLES(DEB_CYCLES)) u_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (deb_raw[i]),
            .filt  (deb_filt[i])
         );
      end
   endgenerate

   logic gate_lvl;
   logic trig_lvl;
   assign gate_lvl = ctrl_q.deb_en ? deb_filt[0] : deb_raw[0];
   assign trig_lvl = ctrl_q.deb_en ? deb_filt[1] : deb_raw[1];

   // edge detection
   logic trig_prev_q;
   logic ext_prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_prev_q <= 1'b0;
         ext_prev_q  <= 1'b0;
      end else begin
         trig_prev_q <= trig_lvl;
         ext_prev_q  <= pin_sync[1];
      end
   end

   logic ext_rise;
   logic trig_hit;
   logic gate_on;
   logic armed;
   logic ext_sel;
   logic tick;
   logic start;

   assign ext_rise = pin_sync[1] && !ext_prev_q;

   always_comb begin
      unique case (ctrl_q.trig_cfg)
         LVL_HIGH: trig_hit = trig_lvl && !trig_prev_q;
         LVL_LOW:  trig_hit = !trig_lvl && trig_prev_q;
         default:  trig_hit = 1'b0;
      endcase
      unique case (ctrl_q.gate_cfg)
         LVL_HIGH: gate_on = gate_lvl;
         LVL_LOW:  gate_on = !gate_lvl;
         default:  gate_on = 1'b0;
      endcase
   end

   assign armed   = (ctrl_q.mode == MODE_ONESHOT);
   assign ext_sel = (ctrl_q.clk_src == CLKSRC_EXT) && (ctrl_q.clkin_cfg == CLKIN_ON);
   assign tick    = armed && !gate_on && (ext_sel ? ext_rise : 1'b1);
   assign start   = armed && !gate_on && trig_hit;

   // phase sequencer
   phase_t phase;
   logic   phase_end;

   ospg_phase_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed),
      .start     (start),
      .tick      (tick),
      .len_a     (len_a_q),
      .len_b     (len_b_q),
      .phase     (phase),
      .phase_end (phase_end)
   );

   assign pulse_out = ctrl_q.act_high ? (phase == ST_HIGH) : (phase != ST_HIGH);

   // sticky completion flag
   logic irq_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          irq_q <= 1'b0;
      else if (phase_end && ctrl_q.irq_en) irq_q <= 1'b1;
      else if (ctrl_wr)                    irq_q <= 1'b0;
   end
   assign irq = irq_q;

   assert_ext_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise |=> !ext_rise);

   assert_irq_set_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_end && ctrl_q.irq_en) |=> irq_q);

   assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ctrl_wr) |=> irq_q);

   assert_gate_holds_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_on && !wr_en) |=> $stable(pulse_out));

   assert_idle_when_disarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !wr_en) |=> (phase == ST_IDLE));
endmodule

// File: tb/sim_oneshot_pulse_gen.sv
module sim_oneshot_pulse_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        gate_in = 1'b0;
   logic        clk_in = 1'b0;
   logic        trig_in = 1'b0;
   logic        pulse_out;
   logic        irq;

   int checks = 0;
   int fails = 0;
   bit done = 0;
   bit ext_run = 0;
   logic [1:0] ext_ph = '0;

   always #2 clk = ~clk;  // 250 MHz

   oneshot_pulse_gen u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .gate_in(gate_in), .clk_in(clk_in), .trig_in(trig_in),
      .pulse_out(pulse_out), .irq(irq)
   );

   // external count clock: four system cycles per period
   always @(negedge clk) begin
      if (ext_run) begin
         ext_ph  <= ext_ph + 2'd1;
         clk_in  <= ext_ph[1];
      end else begin
         clk_in  <= 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic setup(input logic [15:0] c, input logic [15:0] a, input logic [15:0] b);
      wr(2'd1, a);
      wr(2'd2, b);
      wr(2'd0, c);
      repeat (6) @(negedge clk);
   endtask

   // drive the trigger to lvl, count clock edges until pulse_out==act, then measure width
   task automatic measure(input logic lvl, input logic act, input int hold,
                          input int gate_at, input int gate_len, input int limit,
                          output int n, output int w);
      bit found = 0;
      n = 0; w = 0;
      trig_in = lvl;
      while (!found && n < limit) begin
         @(posedge clk); n++;
         @(negedge clk);
         if (n == hold) trig_in = ~lvl;
         if (gate_len > 0 && n == gate_at) gate_in = 1'b1;
         if (gate_len > 0 && n == gate_at + gate_len) gate_in = 1'b0;
         if (pulse_out == act) found = 1;
      end
      trig_in = ~lvl;
      while (found && pulse_out == act && w < limit) begin
         w++;
         @(posedge clk); @(negedge clk);
      end
   endtask

   // stimulus table: control word, delay constant, width constant
   localparam int NV = 5;
   localparam logic [15:0] V_CTRL [NV] = '{16'h020F, 16'h820F, 16'h0207, 16'h8207, 16'h160F};
   localparam logic [15:0] V_A    [NV] = '{16'd4, 16'd10, 16'd2, 16'd1, 16'd100};
   localparam logic [15:0] V_B    [NV] = '{16'd1, 16'd5, 16'd3, 16'd1, 16'd37};

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int n, w;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pulse_out == 1'b1, "R1 idle output", int'(pulse_out), 1);
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(pulse_out == 1'b1 && irq == 1'b0, "R1 after release", int'(pulse_out), 1);

      // table walk: R4 R6 R9 R11
      for (int i = 0; i < NV; i++) begin
         setup(V_CTRL[i], V_A[i], V_B[i]);
         chk(pulse_out == ~V_CTRL[i][3], "R6 idle level", int'(pulse_out), int'(~V_CTRL[i][3]));
         measure(1'b1, V_CTRL[i][3], 2, 0, 0, 400, n, w);
         chk(n == 3 + int'(V_A[i]), "R4 delay stretch", n, 3 + int'(V_A[i]));
         chk(w == int'(V_B[i]), "R4 width stretch", w, int'(V_B[i]));
         chk(irq == V_CTRL[i][15], "R11 flag at end", int'(irq), int'(V_CTRL[i][15]));
         if (V_CTRL[i][15]) begin
            wr(2'd3, 16'h0000);  // R12 unused address
            chk(irq == 1'b1, "R12 addr3 write leaves flag", int'(irq), 1);
            wr(2'd0, V_CTRL[i]);
            @(negedge clk);
            chk(irq == 1'b0, "R11 cleared by control write", int'(irq), 0);
         end
      end

      // R12: address 3 write does not alter constants
      setup(16'h020F, 16'd6, 16'd3);
      wr(2'd3, 16'hFFFF);
      measure(1'b1, 1'b1, 2, 0, 0, 100, n, w);
      chk(n == 9 && w == 3, "R12 constants intact", n * 100 + w, 903);

      // R2 other mode ignores triggers
      setup(16'h020E, 16'd2, 16'd2);
      measure(1'b1, 1'b1, 2, 0, 0, 40, n, w);
      chk(n == 40 && pulse_out == 1'b0, "R2 disarmed", n, 40);

      // R3 trigger codes
      setup(16'h000F, 16'd2, 16'd2);
      measure(1'b1, 1'b1, 2, 0, 0, 40, n, w);
      chk(n == 40, "R3 code 00 ignored", n, 40);
      setup(16'h030F, 16'd2, 16'd2);
      measure(1'b1, 1'b1, 2, 0, 0, 40, n, w);
      chk(n == 40, "R3 code 11 ignored", n, 40);
      trig_in = 1'b1;
      repeat (6) @(negedge clk);
      setup(16'h010F, 16'd5, 16'd2);
      measure(1'b0, 1'b1, 2, 0, 0, 100, n, w);
      chk(n == 8 && w == 2, "R3 falling edge", n, 8);
      trig_in = 1'b0;
      repeat (6) @(negedge clk);

      // R7 retrigger mid delay
      setup(16'h020F, 16'd10, 16'd5);
      trig_in = 1'b1; repeat (2) @(negedge clk);
      trig_in = 1'b0; repeat (4) @(negedge clk);
      measure(1'b1, 1'b1, 2, 0, 0, 100, n, w);
      chk(n == 13, "R7 restart delay", n, 13);
      chk(w == 5, "R7 width after restart", w, 5);

      // R8 hold-off freezes delay stretch
      setup(16'h022F, 16'd10, 16'd5);
      measure(1'b1, 1'b1, 2, 3, 6, 100, n, w);
      chk(n == 19, "R8 freeze extends delay", n, 19);
      chk(w == 5, "R8 width unchanged", w, 5);
      // R8 trigger ignored while held off
      gate_in = 1'b1;
      repeat (4) @(negedge clk);
      measure(1'b1, 1'b1, 2, 0, 0, 40, n, w);
      gate_in = 1'b0;
      repeat (30) @(negedge clk);
      chk(n == 40 && pulse_out == 1'b0, "R8 trigger ignored", n, 40);

      // R10 debounce
      setup(16'h220F, 16'd5, 16'd2);
      measure(1'b1, 1'b1, 2, 0, 0, 40, n, w);
      chk(n == 40, "R10 short glitch rejected", n, 40);
      measure(1'b1, 1'b1, 8, 0, 0, 100, n, w);
      chk(n == 12, "R10 filtered latency", n, 12);

      // R9 external count clock
      ext_run = 1;
      setup(16'h164F, 16'd3, 16'd5);
      measure(1'b1, 1'b1, 2, 0, 0, 200, n, w);
      chk(w == 20, "R9 external ticks", w, 20);
      ext_run = 0;

      // R5 zero constant
      setup(16'h020F, 16'd0, 16'd1);
      measure(1'b1, 1'b1, 2, 0, 0, 70000, n, w);
      chk(n == 65539, "R5 zero wraps", n, 65539);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule